// File: doc/BRIEF.md
# Two-Level Sample Accumulator

This block integrates a stream of signed per-sample products in two nested stages. The inner stage adds up a programmable number of consecutive valid samples into a partial sum. Each time that count is reached, the outer stage folds the partial sum into a running total. The interval is complete when the outer stage has absorbed a programmable number of partial sums, so it spans the product of the two counts in accepted samples.

When an interval completes, the total is copied into a holding register and a one-cycle completion pulse fires. Both stages clear on the same edge, so the next sample starts a fresh interval and none is lost. Software sees the latched total, the pulse and a busy flag. A zero count is treated as one. The counts are captured when an interval starts, so edits made during an interval take effect only in the next one. Dropping the enable abandons the interval in progress and leaves the last latched total in place.

Top module: `dual_stage_accum`

## Requirements
- R1: The inner stage sums exactly `pre_cnt` accepted samples (`en` and `smp_vld` high on a rising edge) into one partial sum. Idle cycles with `smp_vld` low add nothing.
- R2: An interval completes after exactly `pre_cnt` × `cyc_cnt` accepted samples. `done` never rises earlier in the interval.
- R3: `done` is high for the single cycle after the edge that accepted the final sample of the interval. `total` takes its new value in that same cycle and holds it at all other times.
- R4: `total` is the two's-complement sum of the 24-bit signed samples, sign-extended to 56 bits, with no saturation.
- R5: A value of 0 in `pre_cnt` or in `cyc_cnt` behaves exactly like 1.
- R6: `pre_cnt` and `cyc_cnt` are captured when the first sample of an interval is accepted. Changes made later in that interval do not affect it.
- R7: A sample accepted on the edge right after a completing sample belongs wholly to the next interval, so intervals can run back to back with no gap.
- R8: While `en` is low, samples are ignored, both stages and their counters clear, `busy` and `done` are low, and `total` keeps its value.
- R9: `busy` is high from the edge that accepts an interval's first sample until the edge that completes the interval.
- R10: After synchronous reset, `total` is 0 and `done` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accumulation enable |
| smp_vld | input | 1 | Sample strobe |
| smp_data | input | 24 | Signed sample |
| pre_cnt | input | 16 | Samples per partial sum |
| cyc_cnt | input | 16 | Partial sums per interval |
| total | output | 56 | Latched interval total |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Interval in progress |

## Verification
The assertions assume that the inputs are held at rest during reset, with `en` and `smp_vld` low, so that the first look back after reset sees no accepted sample. They also assume that a counter's index can only exceed its limit while no interval is active, which holds because the limits are frozen while `busy` is high. The bench drives every input at the falling edge with `smp_vld` low during reset. It changes the counts only between intervals, except in the test that is meant to show a mid-interval change being ignored.

// File: rtl/acc2_pkg.sv
package acc2_pkg;
    localparam int SMP_W = 24;
    localparam int L1_W  = 40;
    localparam int L2_W  = 56;
    localparam int CNT_W = 16;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        cnt_t pre;
        cnt_t cyc;
    } limits_t;

    // Zero in a count register means a single step.
    function automatic cnt_t eff_count(input cnt_t raw);
        return (raw == '0) ? cnt_t'(1) : raw;
    endfunction
endpackage

// File: rtl/acc2_limits.sv
module acc2_limits
    import acc2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    busy,
    input  cnt_t    pre_raw,
    input  cnt_t    cyc_raw,
    output limits_t use_lim
);
    limits_t live;
    limits_t held;

    always_comb begin
        live.pre = eff_count(pre_raw);
        live.cyc = eff_count(cyc_raw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held.pre <= cnt_t'(1);
            held.cyc <= cnt_t'(1);
        end else if (start) begin
            held <= live;
        end
    end

    // While an interval runs the captured limits apply; otherwise the live ones do.
    assign use_lim = busy ? held : live;

    // R5: captured limits are never zero
    a_r5_held_nonzero: assert property (@(posedge clk) disable iff (rst)
        (held.pre != '0) && (held.cyc != '0));
endmodule

// File: rtl/acc2_counter.sv
module acc2_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] lim,
    output logic         last
);
    logic [W-1:0] idx;

    assign last = (idx == lim - W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx <= '0;
        end else if (step) begin
            idx <= last ? '0 : idx + W'(1);
        end
    end

    // R1: the position within the current group stays below its limit
    a_r1_idx_below_limit: assert property (@(posedge clk) disable iff (rst)
        idx < lim);
endmodule

// File: rtl/acc2_stage.sv
module acc2_stage #(
    parameter int IN_W  = 24,
    parameter int OUT_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add,
    input  logic             flush,
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] sum_next
);
    localparam int EXT_W = OUT_W - IN_W;

    logic [OUT_W-1:0] acc;
    logic [OUT_W-1:0] ext;

    assign ext      = {{EXT_W{din[IN_W-1]}}, din};
    assign sum_next = acc + ext;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (add) begin
            acc <= flush ? '0 : sum_next;
        end
    end

    // R7: a group boundary leaves the stage empty for the next sample
    a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (add && flush && !clr) |=> (acc == '0));
endmodule

// File: rtl/dual_stage_accum.sv
module dual_stage_accum
    import acc2_pkg::*;
#(
    parameter int SW = SMP_W,
    parameter int W1 = L1_W,
    parameter int W2 = L2_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          smp_vld,
    input  logic [SW-1:0] smp_data,
    input  logic [CW-1:0] pre_cnt,
    input  logic [CW-1:0] cyc_cnt,
    output logic [W2-1:0] total,
    output logic          done,
    output logic          busy
);
    logic          take;
    logic          clr;
    logic          last1;
    logic          last2;
    logic          wrap1;
    logic          wrap2;
    limits_t       lim;
    logic [W1-1:0] part_next;
    logic [W2-1:0] tot_next;

    assign take  = en && smp_vld;
    assign clr   = !en;
    assign wrap1 = take && last1;
    assign wrap2 = wrap1 && last2;

    acc2_limits u_lim (
        .clk     (clk),
        .rst     (rst),
        .start   (take && !busy),
        .busy    (busy),
        .pre_raw (cnt_t'(pre_cnt)),
        .cyc_raw (cnt_t'(cyc_cnt)),
        .use_lim (lim)
    );

    acc2_counter #(.W(CW)) u_cnt_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .step (take),
        .lim  (lim.pre),
        .last (last1)
    );

    acc2_counter #(.W(CW)) u_cnt_cyc (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .step (wrap1),
        .lim  (lim.cyc),
        .last (last2)
    );

    acc2_stage #(.IN_W(SW), .OUT_W(W1)) u_stage_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .add      (take),
        .flush    (wrap1),
        .din      (smp_data),
        .sum_next (part_next)
    );

    acc2_stage #(.IN_W(W1), .OUT_W(W2)) u_stage_cyc (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .add      (wrap1),
        .flush    (wrap2),
        .din      (part_next),
        .sum_next (tot_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            total <= '0;
            done  <= 1'b0;
            busy  <= 1'b0;
        end else begin
            done <= wrap2;
            if (wrap2) begin
                total <= tot_next;
            end
            if (!en || wrap2) begin
                busy <= 1'b0;
            end else if (take) begin
                busy <= 1'b1;
            end
        end
    end

    // R3: the held total moves only together with the completion pulse
    a_r3_total_moves_with_done: assert property (@(posedge clk) disable iff (rst)
        (total != $past(total)) |-> done);

    // R2: completion always follows an accepted sample
    a_r2_done_after_sample: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(take));

    // R8: disabling drops busy and suppresses completion
    a_r8_disable_idles: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!busy && !done));

    // R9: an accepted sample leaves the block busy or just completed
    a_r9_busy_after_take: assert property (@(posedge clk) disable iff (rst)
        take |=> (busy || done));
endmodule

// File: tb/tb_dual_stage_accum.sv
module tb_dual_stage_accum;
    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        smp_vld;
    logic [23:0] smp_data;
    logic [15:0] pre_cnt;
    logic [15:0] cyc_cnt;
    logic [55:0] total;
    logic        done;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dual_stage_accum dut (
        .clk(clk), .rst(rst), .en(en), .smp_vld(smp_vld), .smp_data(smp_data),
        .pre_cnt(pre_cnt), .cyc_cnt(cyc_cnt), .total(total), .done(done), .busy(busy)
    );

    localparam int NV = 6;
    localparam int V_PRE [NV]  = '{4, 1, 0, 3, 7, 2};
    localparam int V_CYC [NV]  = '{3, 1, 5, 0, 4, 8};
    localparam int V_BASE[NV]  = '{100, -5, 1000, -8388608, 8388607, -50000};
    localparam int V_STEP[NV]  = '{7, 0, -300, 0, -1, 12345};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint tot_s();
        return longint'($signed(total));
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic send(input longint val);
        smp_vld  = 1'b1;
        smp_data = 24'(val);
        @(negedge clk);
        smp_vld  = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        longint expv;
        longint prev;
        longint a;
        bit     early;
        int     n;
        rst = 1'b1; en = 1'b0; smp_vld = 1'b0; smp_data = '0;
        pre_cnt = 16'd1; cyc_cnt = 16'd1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10
        chk(total == 56'd0, "R10 total", tot_s(), 0);
        chk(!done, "R10 done", done, 0);
        chk(!busy, "R10 busy", busy, 0);
        en = 1'b1;
        @(negedge clk);

        // Vector walk: R1, R2, R3, R4, R5, R9
        for (int v = 0; v < NV; v++) begin
            pre_cnt = 16'(V_PRE[v]);
            cyc_cnt = 16'(V_CYC[v]);
            n = ((V_PRE[v] == 0) ? 1 : V_PRE[v]) * ((V_CYC[v] == 0) ? 1 : V_CYC[v]);
            expv = 0;
            early = 1'b0;
            for (int k = 0; k < n; k++) begin
                a = longint'(V_BASE[v]) + longint'(k) * longint'(V_STEP[v]);
                expv += a;
                if (k % 3 == 2) @(negedge clk);
                send(a);
                if (k == 0 && n > 1) chk(busy, "R9 busy after first sample", busy, 1);
                if (k < n - 1 && done) early = 1'b1;
            end
            chk(!early, "R2 no early done", early, 0);
            chk(done, "R3 done after last sample", done, 1);
            chk(tot_s() == expv, "R1/R4/R5 total", tot_s(), expv);
            chk(!busy, "R9 busy clears", busy, 0);
            @(negedge clk);
            chk(!done, "R3 done single cycle", done, 0);
            chk(tot_s() == expv, "R3 total holds", tot_s(), expv);
        end

        // R6: counts edited mid-interval do not apply
        pre_cnt = 16'd2; cyc_cnt = 16'd2;
        send(10);
        pre_cnt = 16'd5; cyc_cnt = 16'd9;
        send(20);
        send(30);
        chk(!done, "R6 no done at 3", done, 0);
        send(40);
        chk(done, "R6 done at 4", done, 1);
        chk(tot_s() == 100, "R6 total", tot_s(), 100);
        pre_cnt = 16'd1; cyc_cnt = 16'd2;
        @(negedge clk);

        // R7: back-to-back intervals, pre=1 cyc=2
        send(-7);
        send(3);
        chk(done, "R7 first done", done, 1);
        chk(tot_s() == -4, "R7 first total", tot_s(), -4);
        send(11);
        chk(!done, "R7 no done mid", done, 0);
        send(-2);
        chk(done, "R7 second done", done, 1);
        chk(tot_s() == 9, "R7 second total", tot_s(), 9);

        // R8: disable mid-interval
        pre_cnt = 16'd2; cyc_cnt = 16'd3;
        @(negedge clk);
        prev = tot_s();
        send(500); send(600); send(700);
        en = 1'b0;
        @(negedge clk);
        chk(!busy, "R8 busy low", busy, 0);
        chk(tot_s() == prev, "R8 total kept", tot_s(), prev);
        send(9999);
        chk(!done, "R8 ignored sample", done, 0);
        chk(tot_s() == prev, "R8 total kept after sample", tot_s(), prev);
        en = 1'b1;
        @(negedge clk);
        expv = 0;
        for (int k = 1; k <= 6; k++) begin
            send(longint'(k) * 3);
            expv += longint'(k) * 3;
        end
        chk(done, "R8 fresh interval done", done, 1);
        chk(tot_s() == expv, "R8 fresh interval total", tot_s(), expv);
        @(negedge clk);
        finish_run();
    end
endmodule